// File: doc/BRIEF.md
# Store Queue with Age-Qualified Load Forwarding

This block keeps in-flight stores in a circular buffer in program order until they retire. A store takes a slot at the tail when it is allocated and gets an age sequence number. Its address and its data then arrive as two separate operations, each naming the slot, so one may land before the other. Retirement removes the store at the head and presents its address and data on a write port toward the L1 data cache in that same cycle.

A load presents its address and sequence number. In the same cycle the queue returns the data of the nearest store that is older than the load and has the same address. If that store's data is still missing, the queue reports a stall. If no older store matches, the load takes the data cache result, which is looked up in parallel outside this block.

The age search walks the slots from head to tail, so it stays correct after the buffer wraps. A flush removes every store younger than a given sequence number by pulling the tail back.

Top module: `stfwd_queue`

## Requirements
- R1: After reset the queue is empty: `alloc_ready`=1, `alloc_idx`=0, `ld_hit`=0, `ld_stall`=0 and `wr_valid`=0.
- R2: An accepted allocation takes the slot shown on `alloc_idx` and the slot index then advances by one, modulo DEPTH. Once DEPTH stores are held, `alloc_ready` is 0, a request is refused and `alloc_idx` does not move.
- R3: Address writes (`sta_*`) and data writes (`std_*`) go to the slot they name, independently of each other. A freshly allocated slot has neither. A write that names a slot holding no store is ignored.
- R4: When the selected store has valid data, `ld_hit`=1 and `ld_data` equals that store's data. Otherwise `ld_data` is 0.
- R5: A store with sequence s is older than a load with sequence q when bit SEQ_W-1 of (s-q) mod 2^SEQ_W is 1. A store whose sequence is equal to or younger than the load's is never forwarded.
- R6: When several older stores match the load address, the youngest of them is the one selected.
- R7: A store whose address is not yet written is skipped by the search. If the selected store has its address but not its data, `ld_stall`=1 and `ld_hit`=0.
- R8: With `retire_valid`=1 and a head store holding both address and data, `wr_valid`=1 and `wr_addr`/`wr_data` carry the head store in that cycle, and the store is gone in the next cycle. If the queue is empty or the head store is incomplete, `wr_valid`=0 and nothing is removed.
- R9: Search and selection stay correct when the live stores wrap past the last slot back to slot 0.
- R10: With `flush_valid`=1, every store younger than `flush_seq` is removed and the tail moves back. In that cycle a flush takes priority over both allocation and retirement.
- R11: A load looked up in the same cycle that the head store retires is still forwarded from that store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a slot at the tail |
| alloc_seq | input | SEQ_W | Sequence number of the allocated store |
| alloc_ready | output | 1 | Queue not full |
| alloc_idx | output | log2(DEPTH) | Slot the next allocation takes |
| sta_valid | input | 1 | Address write strobe |
| sta_idx | input | log2(DEPTH) | Slot for the address write |
| sta_addr | input | ADDR_W | Store address |
| std_valid | input | 1 | Data write strobe |
| std_idx | input | log2(DEPTH) | Slot for the data write |
| std_data | input | DATA_W | Store data |
| ld_addr | input | ADDR_W | Load address to search |
| ld_seq | input | SEQ_W | Load sequence number |
| ld_hit | output | 1 | Forwarded data valid |
| ld_stall | output | 1 | Nearest older match lacks data |
| ld_data | output | DATA_W | Forwarded data |
| retire_valid | input | 1 | Retire the head store |
| wr_valid | output | 1 | Cache write valid |
| wr_addr | output | ADDR_W | Cache write address |
| wr_data | output | DATA_W | Cache write data |
| flush_valid | input | 1 | Remove stores younger than flush_seq |
| flush_seq | input | SEQ_W | Sequence number at which the flush cuts |

## Verification
The load search and head retirement can happen in the same cycle. If the retiring store is also the one a load needs, the search must still see it. The bench provokes this by holding a load on the head store's address while `retire_valid` is high. In that cycle it requires both `wr_valid` and the forwarded data. In the next cycle it requires a miss for the same load. Flush against allocation is judged in the same way: a flush and an allocation are raised together, and the bench then checks that `alloc_idx` reflects the flush alone.

// File: rtl/stfwd_pkg.sv
package stfwd_pkg;

  typedef enum logic [1:0] {
    LK_MISS  = 2'd0,
    LK_HIT   = 2'd1,
    LK_STALL = 2'd2
  } lk_kind_e;

  // a is older than b when the top bit of (a-b) within w bits is set
  function automatic logic seq_before(input logic [31:0] a,
                                      input logic [31:0] b,
                                      input int unsigned w);
    logic [31:0] diff;
    diff = (a - b) << (32 - w);
    return diff[31];
  endfunction

endpackage

// File: rtl/stfwd_ptrs.sv
module stfwd_ptrs #(
  parameter int DEPTH = 8,
  parameter int PW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_req,
  input  logic             retire_req,
  input  logic             flush_req,
  input  logic [PW:0]      keep_cnt,
  output logic [PW:0]      head_q,
  output logic [PW:0]      tail_q,
  output logic [PW:0]      count,
  output logic             full,
  output logic             empty,
  output logic [DEPTH-1:0] live,
  output logic             alloc_fire,
  output logic             retire_fire
);

  localparam logic [PW:0] ONE = (PW+1)'(1);

  assign count       = tail_q - head_q;
  assign full        = (head_q[PW] != tail_q[PW]) && (head_q[PW-1:0] == tail_q[PW-1:0]);
  assign empty       = (head_q == tail_q);
  assign alloc_fire  = alloc_req && !full && !flush_req;
  assign retire_fire = retire_req && !empty && !flush_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else if (flush_req) begin
      tail_q <= head_q + keep_cnt;
    end else begin
      if (alloc_fire)  tail_q <= tail_q + ONE;
      if (retire_fire) head_q <= head_q + ONE;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_live
    logic [PW-1:0] rel;
    assign rel     = PW'(i) - head_q[PW-1:0];
    assign live[i] = ({1'b0, rel} < count);
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (PW+1)'(DEPTH)); // R2
  AST_FULL_HOLDS_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !flush_req) |=> (tail_q == $past(tail_q))); // R2
  AST_RETIRE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    retire_fire |=> (head_q == $past(head_q) + ONE)); // R8
  AST_FLUSH_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> (count <= $past(count))); // R10

endmodule

// File: rtl/stfwd_entries.sv
module stfwd_entries #(
  parameter int DEPTH  = 8,
  parameter int PW     = 3,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SEQ_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_fire,
  input  logic [PW-1:0]     alloc_slot,
  input  logic [SEQ_W-1:0]  alloc_seq,
  input  logic              sta_valid,
  input  logic [PW-1:0]     sta_idx,
  input  logic [ADDR_W-1:0] sta_addr,
  input  logic              std_valid,
  input  logic [PW-1:0]     std_idx,
  input  logic [DATA_W-1:0] std_data,
  input  logic [DEPTH-1:0]  live,
  output logic [SEQ_W-1:0]  e_seq  [DEPTH],
  output logic [ADDR_W-1:0] e_addr [DEPTH],
  output logic [DATA_W-1:0] e_data [DEPTH],
  output logic [DEPTH-1:0]  e_av,
  output logic [DEPTH-1:0]  e_dv
);

  logic [DEPTH-1:0] sta_hit, std_hit, new_hit;

  for (genvar i = 0; i < DEPTH; i++) begin : g_dec
    assign sta_hit[i] = sta_valid && (sta_idx == PW'(i)) && live[i];
    assign std_hit[i] = std_valid && (std_idx == PW'(i)) && live[i];
    assign new_hit[i] = alloc_fire && (alloc_slot == PW'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_av <= '0;
      e_dv <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        e_seq[i]  <= '0;
        e_addr[i] <= '0;
        e_data[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (new_hit[i]) begin
          e_seq[i] <= alloc_seq;
          e_av[i]  <= 1'b0;
          e_dv[i]  <= 1'b0;
        end else begin
          if (sta_hit[i]) begin
            e_addr[i] <= sta_addr;
            e_av[i]   <= 1'b1;
          end
          if (std_hit[i]) begin
            e_data[i] <= std_data;
            e_dv[i]   <= 1'b1;
          end
        end
      end
    end
  end

  AST_ALLOC_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> (!e_av[$past(alloc_slot)] && !e_dv[$past(alloc_slot)])); // R3

endmodule

// File: rtl/stfwd_search.sv
module stfwd_search #(
  parameter int DEPTH  = 8,
  parameter int PW     = 3,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SEQ_W  = 8
) (
  input  logic [PW-1:0]     head_idx,
  input  logic [DEPTH-1:0]  live,
  input  logic [SEQ_W-1:0]  e_seq  [DEPTH],
  input  logic [ADDR_W-1:0] e_addr [DEPTH],
  input  logic [DATA_W-1:0] e_data [DEPTH],
  input  logic [DEPTH-1:0]  e_av,
  input  logic [DEPTH-1:0]  e_dv,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [SEQ_W-1:0]  ld_seq,
  output stfwd_pkg::lk_kind_e kind,
  output logic [PW-1:0]     sel_idx,
  output logic [DATA_W-1:0] sel_data
);
  import stfwd_pkg::*;

  logic [DEPTH-1:0] cand;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cand
    assign cand[i] = live[i] && e_av[i] && (e_addr[i] == ld_addr) &&
                     seq_before(32'(e_seq[i]), 32'(ld_seq), SEQ_W);
  end

  // walk from oldest to youngest; the last match is the nearest older store
  always_comb begin
    logic          found;
    logic [PW-1:0] idx;
    found   = 1'b0;
    sel_idx = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head_idx + PW'(k);
      if (cand[idx]) begin
        found   = 1'b1;
        sel_idx = idx;
      end
    end
    if (!found)              kind = LK_MISS;
    else if (e_dv[sel_idx])  kind = LK_HIT;
    else                     kind = LK_STALL;
    sel_data = e_data[sel_idx];
  end

endmodule

// File: rtl/stfwd_queue.sv
module stfwd_queue #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SEQ_W  = 8,
  localparam int PW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [SEQ_W-1:0]  alloc_seq,
  output logic              alloc_ready,
  output logic [PW-1:0]     alloc_idx,
  input  logic              sta_valid,
  input  logic [PW-1:0]     sta_idx,
  input  logic [ADDR_W-1:0] sta_addr,
  input  logic              std_valid,
  input  logic [PW-1:0]     std_idx,
  input  logic [DATA_W-1:0] std_data,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [SEQ_W-1:0]  ld_seq,
  output logic              ld_hit,
  output logic              ld_stall,
  output logic [DATA_W-1:0] ld_data,
  input  logic              retire_valid,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic              flush_valid,
  input  logic [SEQ_W-1:0]  flush_seq
);
  import stfwd_pkg::*;

  logic [PW:0]       head_q, tail_q, count, keep_cnt;
  logic              full, empty, alloc_fire, retire_fire, head_ready;
  logic [DEPTH-1:0]  live, e_av, e_dv;
  logic [SEQ_W-1:0]  e_seq  [DEPTH];
  logic [ADDR_W-1:0] e_addr [DEPTH];
  logic [DATA_W-1:0] e_data [DEPTH];
  lk_kind_e          kind;
  logic [PW-1:0]     sel_idx;
  logic [DATA_W-1:0] sel_data;
  logic [PW-1:0]     head_idx;

  assign head_idx   = head_q[PW-1:0];
  assign head_ready = e_av[head_idx] && e_dv[head_idx];

  // stores at or older than the flush point survive
  always_comb begin
    keep_cnt = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (live[i] && !seq_before(32'(flush_seq), 32'(e_seq[i]), SEQ_W))
        keep_cnt = keep_cnt + (PW+1)'(1);
    end
  end

  stfwd_ptrs #(.DEPTH(DEPTH), .PW(PW)) u_ptrs (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_req  (alloc_valid),
    .retire_req (retire_valid && head_ready),
    .flush_req  (flush_valid),
    .keep_cnt   (keep_cnt),
    .head_q     (head_q),
    .tail_q     (tail_q),
    .count      (count),
    .full       (full),
    .empty      (empty),
    .live       (live),
    .alloc_fire (alloc_fire),
    .retire_fire(retire_fire)
  );

  stfwd_entries #(.DEPTH(DEPTH), .PW(PW), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                  .SEQ_W(SEQ_W)) u_entries (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_fire(alloc_fire),
    .alloc_slot(tail_q[PW-1:0]),
    .alloc_seq (alloc_seq),
    .sta_valid (sta_valid),
    .sta_idx   (sta_idx),
    .sta_addr  (sta_addr),
    .std_valid (std_valid),
    .std_idx   (std_idx),
    .std_data  (std_data),
    .live      (live),
    .e_seq     (e_seq),
    .e_addr    (e_addr),
    .e_data    (e_data),
    .e_av      (e_av),
    .e_dv      (e_dv)
  );

  stfwd_search #(.DEPTH(DEPTH), .PW(PW), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                 .SEQ_W(SEQ_W)) u_search (
    .head_idx(head_idx),
    .live    (live),
    .e_seq   (e_seq),
    .e_addr  (e_addr),
    .e_data  (e_data),
    .e_av    (e_av),
    .e_dv    (e_dv),
    .ld_addr (ld_addr),
    .ld_seq  (ld_seq),
    .kind    (kind),
    .sel_idx (sel_idx),
    .sel_data(sel_data)
  );

  assign alloc_ready = !full;
  assign alloc_idx   = tail_q[PW-1:0];
  assign ld_hit      = (kind == LK_HIT);
  assign ld_stall    = (kind == LK_STALL);
  assign ld_data     = ld_hit ? sel_data : '0;
  assign wr_valid    = retire_fire;
  assign wr_addr     = e_addr[head_idx];
  assign wr_data     = e_data[head_idx];

  AST_HIT_STALL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_hit && ld_stall)); // R7
  AST_EMPTY_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (!ld_hit && !ld_stall)); // R4
  AST_HIT_OLDER: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hit |-> seq_before(32'(e_seq[sel_idx]), 32'(ld_seq), SEQ_W)); // R5
  AST_WR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (!empty && !flush_valid)); // R8

endmodule

// File: tb/test_stfwd_queue.sv
module test_stfwd_queue;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 9;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        alloc_valid = 0;
  logic [7:0]  alloc_seq = 0;
  logic        alloc_ready;
  logic [2:0]  alloc_idx;
  logic        sta_valid = 0;
  logic [2:0]  sta_idx = 0;
  logic [15:0] sta_addr = 0;
  logic        std_valid = 0;
  logic [2:0]  std_idx = 0;
  logic [31:0] std_data = 0;
  logic [15:0] ld_addr = 0;
  logic [7:0]  ld_seq = 0;
  logic        ld_hit, ld_stall;
  logic [31:0] ld_data;
  logic        retire_valid = 0;
  logic        wr_valid;
  logic [15:0] wr_addr;
  logic [31:0] wr_data;
  logic        flush_valid = 0;
  logic [7:0]  flush_seq = 0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stfwd_queue i_stfwd_queue (.*);

  // load vectors after setup: slots 0..4 hold seq 10,12,14,16,18
  localparam logic [15:0] V_ADDR  [NV] = '{16'h100, 16'h100, 16'h100, 16'h100, 16'h100,
                                           16'h100, 16'h200, 16'h300, 16'h200};
  localparam logic [7:0]  V_SEQ   [NV] = '{8'd11, 8'd10, 8'd9, 8'd15, 8'd17,
                                           8'd20, 8'd13, 8'd20, 8'd12};
  localparam logic        V_HIT   [NV] = '{1, 0, 0, 1, 0, 0, 1, 0, 0};
  localparam logic        V_STALL [NV] = '{0, 0, 0, 0, 1, 1, 0, 0, 0};
  localparam logic [31:0] V_DATA  [NV] = '{32'hA0, 0, 0, 32'hC2, 0, 0, 32'hB1, 0, 0};
  localparam string       V_REQ   [NV] = '{"R4", "R5", "R5", "R6", "R7",
                                           "R7", "R4", "R4", "R5"};

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_alloc(input logic [7:0] s);
    alloc_valid = 1; alloc_seq = s;
    tick();
    alloc_valid = 0;
  endtask

  task automatic do_sta(input logic [2:0] i, input logic [15:0] a);
    sta_valid = 1; sta_idx = i; sta_addr = a;
    tick();
    sta_valid = 0;
  endtask

  task automatic do_std(input logic [2:0] i, input logic [31:0] d);
    std_valid = 1; std_idx = i; std_data = d;
    tick();
    std_valid = 0;
  endtask

  task automatic look(input logic [15:0] a, input logic [7:0] s, input bit eh,
                      input bit es, input logic [31:0] ed, input string req);
    ld_addr = a; ld_seq = s;
    #1;
    chk(ld_hit == eh, req, "ld_hit", 32'(ld_hit), 32'(eh));
    chk(ld_stall == es, req, "ld_stall", 32'(ld_stall), 32'(es));
    chk(ld_data == ed, req, "ld_data", ld_data, ed);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk(alloc_ready == 1, "R1", "alloc_ready", 32'(alloc_ready), 1);
    chk(alloc_idx == 0, "R1", "alloc_idx", 32'(alloc_idx), 0);
    chk(!ld_hit && !ld_stall, "R1", "lookup", 32'({ld_hit, ld_stall}), 0);
    chk(wr_valid == 0, "R1", "wr_valid", 32'(wr_valid), 0);

    // setup
    for (int k = 0; k < 5; k++) begin
      #1;
      chk(alloc_idx == 3'(k), "R2", "alloc_idx", 32'(alloc_idx), 32'(k));
      do_alloc(8'(10 + 2*k));
    end
    do_sta(0, 16'h100); do_std(0, 32'hA0);
    do_sta(1, 16'h200); do_std(1, 32'hB1);
    do_sta(2, 16'h100); do_std(2, 32'hC2);
    do_sta(3, 16'h100);
    do_std(4, 32'hE4);

    for (int v = 0; v < NV; v++)
      look(V_ADDR[v], V_SEQ[v], V_HIT[v], V_STALL[v], V_DATA[v], V_REQ[v]);

    // R3: write to a slot holding no store is ignored
    do_sta(6, 16'h300); do_std(6, 32'h66);
    look(16'h300, 8'd30, 0, 0, 0, "R3");

    // R11: retire head while load looks up the same store
    retire_valid = 1; ld_addr = 16'h100; ld_seq = 8'd11;
    #1;
    chk(wr_valid == 1, "R11", "wr_valid", 32'(wr_valid), 1);
    chk(wr_addr == 16'h100, "R8", "wr_addr", 32'(wr_addr), 32'h100);
    chk(wr_data == 32'hA0, "R8", "wr_data", wr_data, 32'hA0);
    chk(ld_hit && ld_data == 32'hA0, "R11", "ld_data", ld_data, 32'hA0);
    tick();
    retire_valid = 0;
    look(16'h100, 8'd11, 0, 0, 0, "R8");
    retire_valid = 1; tick(); tick(); retire_valid = 1;
    // head is slot 3 without data: retire is refused
    #1;
    chk(wr_valid == 0, "R8", "wr_valid incomplete head", 32'(wr_valid), 0);
    tick();
    retire_valid = 0;
    look(16'h100, 8'd17, 0, 1, 0, "R8");
    do_std(3, 32'hD3);
    do_sta(4, 16'h400);
    look(16'h400, 8'd30, 1, 0, 32'hE4, "R3");

    // R10: flush at 16 removes slot 4, while an allocation is refused
    flush_valid = 1; flush_seq = 8'd16; alloc_valid = 1; alloc_seq = 8'd50;
    retire_valid = 1;
    #1;
    chk(wr_valid == 0, "R10", "wr_valid under flush", 32'(wr_valid), 0);
    tick();
    flush_valid = 0; alloc_valid = 0; retire_valid = 0;
    #1;
    chk(alloc_idx == 3'd4, "R10", "alloc_idx", 32'(alloc_idx), 4);
    look(16'h400, 8'd30, 0, 0, 0, "R10");
    look(16'h100, 8'd30, 1, 0, 32'hD3, "R10");

    // R9/R2: fill to wrap and full
    for (int k = 0; k < 7; k++) do_alloc(8'(20 + 2*k));
    #1;
    chk(alloc_ready == 0, "R2", "alloc_ready full", 32'(alloc_ready), 0);
    chk(alloc_idx == 3'd3, "R2", "alloc_idx full", 32'(alloc_idx), 3);
    do_alloc(8'd99);
    #1;
    chk(alloc_idx == 3'd3, "R2", "alloc_idx refused", 32'(alloc_idx), 3);
    retire_valid = 1;
    #1;
    chk(wr_valid && wr_data == 32'hD3, "R8", "wr_data", wr_data, 32'hD3);
    tick();
    retire_valid = 0;
    #1;
    chk(alloc_ready == 1, "R2", "alloc_ready after retire", 32'(alloc_ready), 1);
    chk(alloc_idx == 3'd3, "R2", "alloc_idx after retire", 32'(alloc_idx), 3);

    // slots 7(seq26),0(seq28),1(seq30) across the wrap
    do_sta(7, 16'h100); do_std(7, 32'h77);
    do_sta(0, 16'h100);
    do_sta(1, 16'h100); do_std(1, 32'h11);
    look(16'h100, 8'd29, 0, 1, 0, "R9");
    look(16'h100, 8'd27, 1, 0, 32'h77, "R9");
    look(16'h100, 8'd31, 1, 0, 32'h11, "R9");
    look(16'h100, 8'd25, 0, 0, 0, "R9");

    summary();
  end
endmodule